// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the interrupt control word that sits beside a multi-channel DMA engine. One 32-bit register mixes three kinds of field:
- plain control bits that software writes and reads back;
- per-channel completion flags that the channels set and software clears by writing a 1;
- a master flag, bit 31, that the block computes itself.

The register changes on a software write, on a cycle in which any channel reports completion, or on both together. On each such cycle the block works out the master condition again. The condition holds when the bus-error bit is set, or when the global enable is set and at least one completion flag is set. The master flag takes the result.

The block forwards an interrupt to the system interrupt controller as a single-cycle request pulse. The pulse is raised only when the master flag goes from clear to set. While the master flag stays set, further flag events produce no new request, so software has to let the condition fall before another request can reach the controller.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000 and the request output is low.
- R2: A write loads exactly the bits in mask 0x00FF803F: bits 0-5 (control), bit 15 (bus error), bits 16-22 (channel enables) and bit 23 (global enable). Bits 6-14 always read 0.
- R3: Completion flag bits 24 to 24+NUM_CH-1 are cleared by a write that has a 1 in the same position. A 0 in that position leaves the flag unchanged.
- R4: A high done_i[n] sets flag bit 24+n at the next clock edge. If the same cycle also has a write with a 1 in that bit, the set wins.
- R5: Every update (a write, or any done_i high) sets bit 31 when bit 15 is 1, or when bit 23 is 1 and any flag in bits 24-30 is 1.
- R6: When the master condition is false after an update, bit 31 reads 0.
- R7: irq_pulse is high for exactly one cycle, in the cycle after an update. It is raised only if the master condition is true after that update and bit 31 was 0 before it.
- R8: In a cycle with no write and no done_i high, the register holds its value and no request is raised.
- R9: Writing 1 to bit 31 has no direct effect. Bit 31 follows only the rule of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| done_i | input | NUM_CH | Per-channel completion, sets flag 24+n |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | Single-cycle request to the interrupt controller |

## Verification
The bench builds the block with its default NUM_CH of 7. With that value every flag position from bit 24 to bit 30 belongs to a channel, so write-1-to-clear can be exercised on the top flag, and a completion on the highest channel can collide with a write that clears it. The sequence drives the master condition through its bus-error term and through its enable-and-flag term. It rises and falls several times, so the first pulse, the suppressed repeats and a fresh pulse after the condition has fallen all appear.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned FLAG_LO    = 24;
  localparam int unsigned FLAG_SLOTS = 7;
  localparam int unsigned BUSERR_BIT = 15;
  localparam int unsigned GEN_BIT    = 23;
  localparam int unsigned MASTER_BIT = 31;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h00FF_803F;

  // Mask covering the flag bits owned by the first n channels.
  function automatic logic [REG_W-1:0] flag_mask(input int unsigned n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < FLAG_SLOTS; i++)
      if (i < n) m[FLAG_LO+i] = 1'b1;
    return m;
  endfunction

  // Master condition evaluated on a candidate register value.
  function automatic logic master_cond(input logic [REG_W-1:0] v);
    return v[BUSERR_BIT] | (v[GEN_BIT] & (|v[FLAG_LO +: FLAG_SLOTS]));
  endfunction
endpackage

// File: rtl/dicr_next_value.sv
module dicr_next_value
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic [REG_W-1:0]  cur,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic [REG_W-1:0]  nxt_base,
  output logic              update
);
  logic [REG_W-1:0]      ctrl_part;
  logic [FLAG_SLOTS-1:0] flags;

  assign ctrl_part = wr_en ? (wr_data & CTRL_MASK) : (cur & CTRL_MASK);

  for (genvar n = 0; n < FLAG_SLOTS; n++) begin : g_flag
    if (n < NUM_CH) begin : g_live
      assign flags[n] = (cur[FLAG_LO+n] & ~(wr_en & wr_data[FLAG_LO+n])) | done_i[n];
    end else begin : g_tied
      assign flags[n] = 1'b0;
    end
  end

  always_comb begin
    nxt_base = ctrl_part;
    nxt_base[FLAG_LO +: FLAG_SLOTS] = flags;
    nxt_base[MASTER_BIT] = 1'b0;
  end

  assign update = wr_en | (|done_i);
endmodule

// File: rtl/dicr_master_eval.sv
module dicr_master_eval
  import dma_irq_pkg::*;
(
  input  logic [REG_W-1:0] nxt_base,
  input  logic             cur_master,
  input  logic             update,
  output logic             cond_now,
  output logic             master_next,
  output logic             fire
);
  assign cond_now    = master_cond(nxt_base);
  assign master_next = update ? cond_now : cur_master;
  assign fire        = update & cond_now & ~cur_master;
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic [31:0]       rd_data,
  output logic              irq_pulse
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] nxt_base;
  logic             update_evt;
  logic             cond_now;
  logic             master_next;
  logic             fire;

  dicr_next_value #(.NUM_CH(NUM_CH)) u_next (
    .cur      (reg_q),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .done_i   (done_i),
    .nxt_base (nxt_base),
    .update   (update_evt)
  );

  dicr_master_eval u_master (
    .nxt_base    (nxt_base),
    .cur_master  (reg_q[MASTER_BIT]),
    .update      (update_evt),
    .cond_now    (cond_now),
    .master_next (master_next),
    .fire        (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q     <= '0;
      irq_pulse <= 1'b0;
    end else begin
      reg_q     <= {master_next, nxt_base[MASTER_BIT-1:0]};
      irq_pulse <= fire;
    end
  end

  assign rd_data = reg_q;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [NUM_CH-1:0] done_i,
  input logic [31:0]       rd_data,
  input logic              irq_pulse,
  input logic              update_evt,
  input logic              cond_now
);
  logic [FLAG_SLOTS-1:0] done_pad;
  assign done_pad = FLAG_SLOTS'(done_i);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[14:6] == 9'd0); // R2

  AST_WRITE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & CTRL_MASK) == ($past(wr_data) & CTRL_MASK))); // R2

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_i) |=> ((rd_data[30:24] & $past(done_pad)) == $past(done_pad))); // R4

  AST_MASTER_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] == (rd_data[15] | (rd_data[23] & (|rd_data[30:24])))); // R5

  AST_MASTER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |=> (rd_data[31] == $past(cond_now))); // R6

  AST_PULSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (rd_data[31] && !$past(rd_data[31]) && $past(update_evt))); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || (|done_i)) |=> ($stable(rd_data) && !irq_pulse)); // R8
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .done_i     (done_i),
  .rd_data    (rd_data),
  .irq_pulse  (irq_pulse),
  .update_evt (update_evt),
  .cond_now   (cond_now)
);

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;
  localparam int unsigned NCH = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] done_i = '0;
  logic [31:0]    rd_data;
  logic           irq_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] val;
    logic        pulse;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model_reg = '0;

  always #5 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .done_i    (done_i),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
  );

  // Reference model, written bit by bit from the requirements.
  task automatic model_step(input bit wr, input logic [31:0] wd, input logic [NCH-1:0] dn,
                            output logic [31:0] nv, output bit pl);
    bit any;
    bit c;
    nv = '0;
    for (int i = 0; i < 31; i++) begin
      if (i <= 5 || (i >= 15 && i <= 23))
        nv[i] = wr ? wd[i] : model_reg[i];               // R2
      else if (i >= 24 && i < 24 + NCH)
        nv[i] = dn[i-24] ? 1'b1 : ((wr && wd[i]) ? 1'b0 : model_reg[i]); // R3 R4
    end
    any = 1'b0;
    for (int f = 24; f <= 30; f++) any = any | nv[f];
    c = nv[15] || (nv[23] && any);                       // R5
    if (wr || dn != '0) begin
      nv[31] = c;                                        // R6 R9
      pl = c && !model_reg[31];                          // R7
    end else begin
      nv[31] = model_reg[31];                            // R8
      pl = 1'b0;
    end
  endtask

  task automatic drive(input bit wr, input logic [31:0] wd, input logic [NCH-1:0] dn,
                       input string tag);
    exp_t e;
    logic [31:0] nv;
    bit pl;
    @(negedge clk);
    wr_en   = wr;
    wr_data = wd;
    done_i  = dn;
    model_step(wr, wd, dn, nv, pl);
    model_reg = nv;
    e.val = nv;
    e.pulse = pl;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares one expected item per clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rd_data !== e.val) begin
          errors++;
          $display("FAIL %s rd_data actual %08h expected %08h", e.tag, rd_data, e.val);
        end
        checks++;
        if (irq_pulse !== e.pulse) begin
          errors++;
          $display("FAIL %s irq_pulse actual %0b expected %0b", e.tag, irq_pulse, e.pulse);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_data !== 32'h0 || irq_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual %08h/%0b expected 00000000/0", rd_data, irq_pulse);
    end
    rst_n = 1'b1;
    checks++;
    if (rd_data !== 32'h0) begin
      errors++;
      $display("FAIL R1 after release actual %08h expected 00000000", rd_data);
    end

    drive(1, 32'h0000_7FC0, '0, "R2 reserved bits");
    drive(1, 32'h8000_0000, '0, "R9 master not writable");
    drive(1, 32'h0080_0015, '0, "R2 ctrl write, R6 no flags");
    drive(0, '0, 7'b000_0001, "R4 R7 first flag raises request");
    drive(0, '0, 7'b000_0100, "R7 second flag no request");
    drive(0, '0, '0, "R8 idle hold");
    drive(1, 32'h0180_0000, '0, "R3 clear flag24 keep flag26");
    drive(1, 32'h0480_0000, '0, "R3 R6 clear last flag");
    drive(1, 32'h0080_8000, '0, "R5 bus error raises request");
    drive(1, 32'h0000_0000, '0, "R6 bus error dropped");
    drive(0, '0, 7'b111_1111, "R5 flags without global enable");
    drive(1, 32'h4080_0000, 7'b100_0000, "R4 set beats clear, R7 request");
    drive(1, 32'h7F00_0000, '0, "R3 clear all flags");
    drive(1, 32'h0080_0000, '0, "R6 enable only");
    drive(0, '0, 7'b000_1000, "R7 fresh request after fall");
    drive(0, '0, '0, "R7 R8 pulse ends");
    drive(1, 32'h0000_0000, 7'b000_0001, "R5 done with enable cleared");
    drive(0, '0, '0, "R8 idle");
    drive(0, '0, '0, "R8 idle");

    @(negedge clk);
    wr_en = 1'b0;
    done_i = '0;
    repeat (3) @(posedge clk);
    #3;
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule